// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a per-cycle pulse-width command into the two gate enables of a synchronous step-down power stage: one for the upper switch and one for the lower switch. A cycle-start pulse opens each switching period and a terminate request ends the upper-switch conduction. Dead time is not a fixed count. Before either switch turns on, the sequencer drops the other switch's enable, waits until a digitized gate-discharge flag for that switch reads high, and then waits a further programmable number of clock cycles.

The sequencer also enforces a minimum upper-switch on-time, during which an early terminate is held back. It enforces a minimum upper-switch off-time in every period, which caps the duty ratio. It also provides a light-load mode in which the lower switch is latched off for the rest of the period once the switch node is seen above zero. That mode is on when the select pin is low, and it is forced on while soft-start is still running. The block has no data stream: every pin is a plain level or a single-cycle control pulse, so there is no valid/ready flow and no back-pressure.

Top module: `gate_dt_seq`

## Requirements
- R1: `ho_en` and `lo_en` are never high in the same cycle.
- R2: When a period starts, `lo_en` falls at the clock edge that samples `cyc_start`. `ho_en` stays low while `lo_fb_low` is 0. `ho_en` rises exactly HI_DLY clock edges after the first edge in this wait that samples `lo_fb_low` = 1, provided the flag stays 1 and the off-time of R6 is met.
- R3: After a terminate, `ho_en` falls first. `lo_en` stays low while `ho_fb_low` is 0. `lo_en` rises exactly LO_DLY edges after the first edge in this wait that samples `ho_fb_low` = 1, provided the flag stays 1.
- R4: A terminate that arrives before `ho_en` has been high for MIN_ON cycles is remembered. `ho_en` then stays high for exactly MIN_ON cycles.
- R5: A terminate that arrives after MIN_ON cycles ends `ho_en` at the clock edge that samples it.
- R6: Between two upper-switch pulses, `ho_en` stays low for at least MIN_OFF cycles. A period requested early rises exactly at MIN_OFF cycles.
- R7: A `cyc_start` that arrives while `ho_en` is high, or during the wait before `lo_en`, is held. Once `lo_en` has been high for one cycle, the next period starts without a further pulse.
- R8: While `de_active` = 1, sampling `zc_above` = 1 with the lower switch on makes `lo_en` fall at that edge and sets `lo_latched` = 1. `lo_en` then stays low for the rest of the period, even after `zc_above` returns to 0.
- R9: With `ccm_sel` = 1 and `ss_busy` = 0, `de_active` = 0 and `zc_above` has no effect on `lo_en`.
- R10: `ss_busy` = 1 forces `de_active` = 1 whatever the value of `ccm_sel`.
- R11: `lo_latched` clears at the edge that starts the next period, and `lo_en` may then rise again in that period.
- R12: `en` = 0 drives both gate enables low in the same cycle and returns the sequencer to idle. After `en` returns to 1, nothing switches until a `cyc_start` pulse.
- R13: After reset, `ho_en`, `lo_en` and `lo_latched` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low forces both gates off |
| cyc_start | input | 1 | One-cycle pulse that opens a switching period |
| pwm_stop | input | 1 | Request to end the upper-switch on-time |
| ho_fb_low | input | 1 | 1 = upper-switch gate is discharged |
| lo_fb_low | input | 1 | 1 = lower-switch gate is discharged |
| zc_above | input | 1 | 1 = switch node is above the zero-cross threshold |
| ccm_sel | input | 1 | 1 = continuous conduction, 0 = light-load latching |
| ss_busy | input | 1 | 1 = soft-start not finished |
| ho_en | output | 1 | Upper-switch gate enable |
| lo_en | output | 1 | Lower-switch gate enable |
| de_active | output | 1 | Light-load latching is in force |
| lo_latched | output | 1 | Lower switch is latched off for this period |

## Verification
Results fall into three timing classes. A gate turn-on is due HI_DLY or LO_DLY edges after the first edge that samples the discharge flag high. A terminate or a zero-cross flag acts at the edge that samples it, so its effect shows one cycle after the input is driven. A drop of `en` acts combinationally within the same cycle. The bench drives inputs and samples outputs on the falling clock edge. It counts falling edges from the moment it raises a feedback flag or drives a request, and it compares that count with the parameter-derived number (delay plus one for turn-on, exactly MIN_ON or MIN_OFF for pulse widths). The `en` check is taken one nanosecond after the drive.

// File: rtl/gds_pkg.sv
package gds_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_PRE_HI = 3'd1,
    SQ_HI_ON  = 3'd2,
    SQ_PRE_LO = 3'd3,
    SQ_LO_ON  = 3'd4
  } sq_state_t;
endpackage

// File: rtl/gds_fb_delay.sv
// Feedback-qualified delay: counts edges with the discharge flag high while armed.
module gds_fb_delay #(
  parameter int unsigned DLY = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic fb_low,
  output logic done
);
  localparam int unsigned CW = $clog2(DLY + 2);
  localparam logic [CW-1:0] LIM = CW'(DLY);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!arm || !fb_low) cnt <= '0;
    else if (cnt < LIM)      cnt <= cnt + 1'b1;
  end

  assign done = arm && fb_low && (cnt >= LIM);
endmodule

// File: rtl/gds_span_timer.sv
// Saturating span counter; met goes high once run has lasted LIMIT cycles.
module gds_span_timer #(
  parameter int unsigned LIMIT     = 20,
  parameter bit          START_MET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic met
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CAP  = CW'(LIMIT);
  localparam logic [CW-1:0] LIM1 = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= START_MET ? CAP : '0;
    else if (!run)      cnt <= '0;
    else if (cnt < CAP) cnt <= cnt + 1'b1;
  end

  assign met = (cnt >= LIM1);
endmodule

// File: rtl/gds_de_latch.sv
// Per-period low-side kill latch; clear wins over set.
module gds_de_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic kill
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       kill <= 1'b0;
    else if (clr_req) kill <= 1'b0;
    else if (set_req) kill <= 1'b1;
  end

  // R11
  kill_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !kill);
endmodule

// File: rtl/gate_dt_seq.sv
module gate_dt_seq
  import gds_pkg::*;
#(
  parameter int unsigned HI_DLY  = 14,
  parameter int unsigned LO_DLY  = 14,
  parameter int unsigned MIN_ON  = 20,
  parameter int unsigned MIN_OFF = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cyc_start,
  input  logic pwm_stop,
  input  logic ho_fb_low,
  input  logic lo_fb_low,
  input  logic zc_above,
  input  logic ccm_sel,
  input  logic ss_busy,
  output logic ho_en,
  output logic lo_en,
  output logic de_active,
  output logic lo_latched
);
  sq_state_t st, st_nx;
  logic stop_seen, start_pend;
  logic hi_wait_done, lo_wait_done;
  logic on_met, off_met;
  logic kill_set, kill_clr;

  gds_fb_delay #(.DLY(HI_DLY)) u_hi_wait (
    .clk(clk), .rst_n(rst_n), .arm(st == SQ_PRE_HI),
    .fb_low(lo_fb_low), .done(hi_wait_done));

  gds_fb_delay #(.DLY(LO_DLY)) u_lo_wait (
    .clk(clk), .rst_n(rst_n), .arm(st == SQ_PRE_LO),
    .fb_low(ho_fb_low), .done(lo_wait_done));

  gds_span_timer #(.LIMIT(MIN_ON), .START_MET(1'b0)) u_on_tmr (
    .clk(clk), .rst_n(rst_n), .run(st == SQ_HI_ON), .met(on_met));

  gds_span_timer #(.LIMIT(MIN_OFF), .START_MET(1'b1)) u_off_tmr (
    .clk(clk), .rst_n(rst_n), .run(st != SQ_HI_ON), .met(off_met));

  always_comb begin
    st_nx = st;
    unique case (st)
      SQ_IDLE:   if (cyc_start)                      st_nx = SQ_PRE_HI;
      SQ_PRE_HI: if (hi_wait_done && off_met)        st_nx = SQ_HI_ON;
      SQ_HI_ON:  if ((pwm_stop || stop_seen) && on_met) st_nx = SQ_PRE_LO;
      SQ_PRE_LO: if (lo_wait_done)                   st_nx = SQ_LO_ON;
      SQ_LO_ON:  if (cyc_start || start_pend)        st_nx = SQ_PRE_HI;
      default:                                       st_nx = SQ_IDLE;
    endcase
    if (!en) st_nx = SQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SQ_IDLE;
    else        st <= st_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          stop_seen <= 1'b0;
    else if (!en || st != SQ_HI_ON)      stop_seen <= 1'b0;
    else if (pwm_stop)                   stop_seen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                start_pend <= 1'b0;
    else if (!en || st == SQ_LO_ON) start_pend <= 1'b0;
    else if (cyc_start && (st == SQ_HI_ON || st == SQ_PRE_LO)) start_pend <= 1'b1;
  end

  assign de_active = ss_busy | ~ccm_sel;
  assign kill_set  = en && (st == SQ_LO_ON) && de_active && zc_above;
  assign kill_clr  = !en || ((st_nx == SQ_PRE_HI) && (st != SQ_PRE_HI));

  gds_de_latch u_de_latch (
    .clk(clk), .rst_n(rst_n), .set_req(kill_set), .clr_req(kill_clr),
    .kill(lo_latched));

  assign ho_en = en && (st == SQ_HI_ON);
  assign lo_en = en && (st == SQ_LO_ON) && !lo_latched;

  // R1
  gate_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ho_en && lo_en));

  // R2
  ho_after_lo_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ho_en) |-> ($past(lo_fb_low) && !$past(lo_en)));

  // R3
  lo_after_ho_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_en) |-> ($past(ho_fb_low) && !$past(ho_en)));

  // R4
  min_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ho_en) && en) |-> $past(on_met));

  // R6
  min_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ho_en) |-> $past(off_met));

  // R8
  latch_blocks_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_latched |-> !lo_en);

  // R10
  ss_forces_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_busy |-> de_active);
endmodule

// File: tb/gate_dt_seq_tb.sv
`timescale 1ns/1ps
module gate_dt_seq_tb;
  localparam int HI_DLY  = 14;
  localparam int LO_DLY  = 14;
  localparam int MIN_ON  = 20;
  localparam int MIN_OFF = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, cyc_start = 1'b0, pwm_stop = 1'b0;
  logic zc_above = 1'b0, ccm_sel = 1'b1, ss_busy = 1'b0;
  logic auto_fb = 1'b1;
  logic ho_fb_auto = 1'b1, lo_fb_auto = 1'b1;
  logic ho_fb_man = 1'b1, lo_fb_man = 1'b1;
  logic ho_fb_low, lo_fb_low;
  logic ho_en, lo_en, de_active, lo_latched;

  int n_chk = 0;
  int n_fail = 0;
  int overlap_cnt = 0;

  always #2.5 clk = ~clk;

  assign ho_fb_low = auto_fb ? ho_fb_auto : ho_fb_man;
  assign lo_fb_low = auto_fb ? lo_fb_auto : lo_fb_man;

  always @(negedge clk) begin
    ho_fb_auto <= !ho_en;
    lo_fb_auto <= !lo_en;
    if (ho_en && lo_en) overlap_cnt <= overlap_cnt + 1;
  end

  gate_dt_seq #(.HI_DLY(HI_DLY), .LO_DLY(LO_DLY), .MIN_ON(MIN_ON), .MIN_OFF(MIN_OFF)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cyc_start(cyc_start), .pwm_stop(pwm_stop),
    .ho_fb_low(ho_fb_low), .lo_fb_low(lo_fb_low), .zc_above(zc_above),
    .ccm_sel(ccm_sel), .ss_busy(ss_busy), .ho_en(ho_en), .lo_en(lo_en),
    .de_active(de_active), .lo_latched(lo_latched));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_start();
    cyc_start = 1'b1; tick(); cyc_start = 1'b0;
  endtask

  task automatic pulse_stop();
    pwm_stop = 1'b1; tick(); pwm_stop = 1'b0;
  endtask

  task automatic wait_hi(input bit lo_sel, output int n);
    n = 0;
    do begin tick(); n++; end while (!(lo_sel ? lo_en : ho_en) && n < 1000);
  endtask

  task automatic full_cycle_to_lo();
    int n;
    repeat (MIN_OFF + 10) tick();
    pulse_start();
    wait_hi(1'b0, n);
    pulse_stop();
    wait_hi(1'b1, n);
  endtask

  task automatic t_reset();
    chk(ho_en == 0 && lo_en == 0, "R13 gates after reset", {ho_en, lo_en}, 0);
    chk(lo_latched == 0, "R13 latch after reset", lo_latched, 0);
    chk(de_active == 0, "R9 de_active with ccm_sel=1", de_active, 0);
    en = 1'b1;
    repeat (5) tick();
    chk(ho_en == 0 && lo_en == 0, "R12 idle until cycle start", {ho_en, lo_en}, 0);
  endtask

  task automatic t_ho_dead();
    int n, bad;
    full_cycle_to_lo();
    repeat (MIN_OFF + 10) tick();
    auto_fb = 1'b0; lo_fb_man = 1'b0; ho_fb_man = 1'b1;
    pulse_start();
    chk(lo_en == 0, "R2 LO drops at cycle start", lo_en, 0);
    bad = 0;
    repeat (6) begin tick(); if (ho_en) bad++; end
    chk(bad == 0, "R2 HO held while LO feedback low", bad, 0);
    lo_fb_man = 1'b1;
    wait_hi(1'b0, n);
    chk(n == HI_DLY + 1, "R2 HO delay after LO discharge", n, HI_DLY + 1);
    auto_fb = 1'b1;
  endtask

  task automatic t_lo_dead();
    int n, bad;
    repeat (MIN_ON + 5) tick();
    auto_fb = 1'b0; ho_fb_man = 1'b0; lo_fb_man = 1'b1;
    pulse_stop();
    chk(ho_en == 0, "R5 HO ends at late stop", ho_en, 0);
    bad = 0;
    repeat (6) begin tick(); if (lo_en) bad++; end
    chk(bad == 0, "R3 LO held while HO feedback low", bad, 0);
    ho_fb_man = 1'b1;
    wait_hi(1'b1, n);
    chk(n == LO_DLY + 1, "R3 LO delay after HO discharge", n, LO_DLY + 1);
    auto_fb = 1'b1;
  endtask

  task automatic t_min_on();
    int n, d;
    repeat (MIN_OFF + 10) tick();
    pulse_start();
    wait_hi(1'b0, n);
    pwm_stop = 1'b1; tick(); pwm_stop = 1'b0;
    d = 1;
    while (ho_en && d < 1000) begin d++; tick(); end
    chk(d == MIN_ON, "R4 early stop deferred to min on-time", d, MIN_ON);
  endtask

  task automatic t_late_stop();
    int n;
    wait_hi(1'b1, n);
    repeat (MIN_OFF + 10) tick();
    pulse_start();
    wait_hi(1'b0, n);
    repeat (29) tick();
    chk(ho_en == 1, "R5 HO still on before late stop", ho_en, 1);
    pulse_stop();
    chk(ho_en == 0, "R5 HO off at edge sampling stop", ho_en, 0);
    wait_hi(1'b1, n);
  endtask

  task automatic t_min_off();
    int n, lo_n;
    repeat (MIN_OFF + 10) tick();
    pulse_start();
    wait_hi(1'b0, n);
    pulse_stop();
    pulse_start();
    chk(ho_en == 1, "R7 start arrives during HO on", ho_en, 1);
    n = 0;
    while (ho_en && n < 1000) begin tick(); n++; end
    n = 0; lo_n = 0;
    while (!ho_en && n < 2000) begin if (lo_en) lo_n++; n++; tick(); end
    chk(n == MIN_OFF, "R6 HO low time equals min off-time", n, MIN_OFF);
    chk(lo_n == 1, "R7 held start runs after one LO cycle", lo_n, 1);
    pulse_stop();
    wait_hi(1'b1, n);
  endtask

  task automatic t_de_latch();
    int n, bad;
    ccm_sel = 1'b0;
    tick();
    chk(de_active == 1, "R8 de_active with ccm_sel=0", de_active, 1);
    zc_above = 1'b1; tick();
    chk(lo_en == 0 && lo_latched == 1, "R8 LO latched off on zero cross",
        {lo_en, lo_latched}, 1);
    zc_above = 1'b0;
    bad = 0;
    repeat (5) begin tick(); if (lo_en) bad++; end
    chk(bad == 0, "R8 LO stays off for rest of period", bad, 0);
    repeat (MIN_OFF + 10) tick();
    pulse_start();
    chk(lo_latched == 0, "R11 latch clears at cycle start", lo_latched, 0);
    wait_hi(1'b0, n);
    pulse_stop();
    wait_hi(1'b1, n);
    chk(lo_en == 1, "R11 LO allowed again next period", lo_en, 1);
  endtask

  task automatic t_ccm();
    ccm_sel = 1'b1; ss_busy = 1'b0;
    tick();
    chk(de_active == 0, "R9 de_active low in continuous mode", de_active, 0);
    zc_above = 1'b1;
    repeat (3) tick();
    chk(lo_en == 1 && lo_latched == 0, "R9 zero cross ignored in continuous mode",
        {lo_en, lo_latched}, 2);
    zc_above = 1'b0;
  endtask

  task automatic t_ss();
    ss_busy = 1'b1;
    tick();
    chk(de_active == 1, "R10 soft-start forces de_active", de_active, 1);
    zc_above = 1'b1; tick();
    chk(lo_en == 0 && lo_latched == 1, "R10 latch forced during soft-start",
        {lo_en, lo_latched}, 1);
    zc_above = 1'b0; ss_busy = 1'b0;
  endtask

  task automatic t_disable();
    int n;
    repeat (MIN_OFF + 10) tick();
    pulse_start();
    wait_hi(1'b0, n);
    en = 1'b0; #1;
    chk(ho_en == 0 && lo_en == 0, "R12 HO off same cycle as enable drop", {ho_en, lo_en}, 0);
    repeat (4) tick();
    en = 1'b1;
    repeat (MIN_OFF + 10) tick();
    chk(ho_en == 0 && lo_en == 0, "R12 idle after re-enable", {ho_en, lo_en}, 0);
    pulse_start();
    wait_hi(1'b0, n);
    chk(n == HI_DLY + 1, "R12 restart after cycle start", n, HI_DLY + 1);
    pulse_stop();
    wait_hi(1'b1, n);
    en = 1'b0; #1;
    chk(lo_en == 0, "R12 LO off same cycle as enable drop", lo_en, 0);
    tick();
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog R1-timeout actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_ho_dead();
    t_lo_dead();
    t_min_on();
    t_late_stop();
    t_min_off();
    t_de_latch();
    t_ccm();
    t_ss();
    t_disable();
    chk(overlap_cnt == 0, "R1 HO and LO never overlap", overlap_cnt, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule